// File: doc/BRIEF.md
# Serial Converter Sample Transmitter

This block sends 16-bit converter samples to a DSP serial port as a single serial bit stream. It runs on the shift clock and drives three outputs: the data line, an active-low frame sync, and an active-low end-of-data indication. A sample request is accepted only when the DSP signals that it is ready to take a frame. When a frame starts, the block copies the sample word, the word/byte framing choice and the primary/secondary flag into holding registers. After that, the input pins can change freely without affecting the frame being sent.

There are two framings. In word framing, the 16 bits go out back to back, and a primary frame ends with a one-cycle low pulse on the end-of-data line. In byte framing, a one-cycle gap separates the upper byte from the lower byte. The end-of-data line goes low at the gap and stays low until the last bit has gone out, so the receiver can tell which byte is the first and which is the second. A secondary (control) frame uses the same framing but never drives end-of-data low.

A request that arrives while a frame is running is remembered. It is served once the block has returned to idle.

Top module: `adc_serial_tx`

## Requirements
- R1: While in reset, and while idle, `dx` is 0, `fsync_n` is 1 and `eod_n` is 1.
- R2: A frame starts at a rising edge where the block is idle, `fs_req` is 1 and a request is present (`smp_valid` is 1 or a request is held). `fsync_n` is 0 for exactly the clock cycle after that edge, which is cycle 0 of the frame. No frame starts while `fs_req` is 0.
- R3: In word framing (`byte_mode`=0), `dx` carries bit 15-(k-1) of the sample in cycle k, for k = 1 to 16, so the MSB goes out first. Each bit changes on the rising edge.
- R4: In a primary word frame, `eod_n` is 0 in cycle 17 only. The block is idle from cycle 18.
- R5: In byte framing (`byte_mode`=1), bits 15 down to 8 go out in cycles 1 to 8. `dx` is 0 in the gap at cycle 9. Bits 7 down to 0 go out in cycles 10 to 17.
- R6: In a primary byte frame, `eod_n` is 0 from cycle 9 through cycle 17 and returns to 1 at cycle 18.
- R7: When `smp_secondary` is 1 at the start of a frame, `eod_n` stays 1 for the whole frame. A secondary word frame is idle from cycle 17.
- R8: `smp_data`, `byte_mode` and `smp_secondary` are captured at the frame start edge. Changing them later in the frame does not change that frame's outputs.
- R9: A `smp_valid` pulse during a frame is held. For a primary word frame, the held request starts the next frame at cycle 19 (`fsync_n` low in cycle 19), using the `smp_data` present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1 selects byte framing, 0 selects word framing |
| smp_valid | input | 1 | Sample request |
| smp_data | input | 16 | Sample word |
| smp_secondary | input | 1 | 1 marks a secondary (control) frame |
| fs_req | input | 1 | DSP ready to accept a frame |
| dx | output | 1 | Serial data, MSB first |
| fsync_n | output | 1 | Active-low frame sync |
| eod_n | output | 1 | Active-low end-of-data |

## Verification
Every result is counted in cycles from the rising edge that accepts the request, which starts cycle 0. The frame sync is due in cycle 0 and data bit 15-(k-1) is due in cycle k. The byte gap falls in cycle 9. End-of-data is due in cycle 17 for word framing and in cycles 9 to 17 for byte framing. A held request starts its frame in cycle 19. The bench drives inputs and samples outputs on the falling edge. This puts each sample in the middle of cycle k, after that cycle's rising edge. The expected bit, sync and strobe values are computed from k, the framing, the secondary flag and the sample word.

// File: rtl/adc_serial_tx.sv
module adc_serial_tx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_secondary,
  input  logic              fs_req,
  output logic              dx,
  output logic              fsync_n,
  output logic              eod_n
);
  localparam int CW   = $clog2(DATA_W);
  localparam int HALF = DATA_W / 2;
  localparam logic [CW-1:0] LAST   = CW'(DATA_W - 1);
  localparam logic [CW-1:0] HLAST  = CW'(HALF - 1);
  localparam logic [CW-1:0] HFIRST = CW'(HALF);

  typedef enum logic [2:0] {IDLE, SYNC, SHIFT, GAP, EOD} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] hold;
  logic              bmode, sec, pend;
  logic              start;

  assign start = (state == IDLE) && fs_req && (pend || smp_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
      hold  <= '0;
      bmode <= 1'b0;
      sec   <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pend <= (pend | smp_valid) & ~start;
      case (state)
        IDLE: if (start) begin
          state <= SYNC;
          hold  <= smp_data;
          bmode <= byte_mode;
          sec   <= smp_secondary;
        end
        SYNC: begin
          state <= SHIFT;
          cnt   <= '0;
        end
        SHIFT: begin
          cnt <= cnt + 1'b1;
          if (bmode && cnt == HLAST)
            state <= GAP;
          else if (cnt == LAST)
            state <= (sec || bmode) ? IDLE : EOD;
        end
        GAP: begin
          state <= SHIFT;
          cnt   <= HFIRST;
        end
        EOD:     state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign dx      = (state == SHIFT) ? hold[LAST - cnt] : 1'b0;
  assign fsync_n = (state != SYNC);
  assign eod_n   = !((state == EOD) ||
                     (bmode && !sec && ((state == GAP) || (state == SHIFT && cnt >= HFIRST))));

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync_n |=> fsync_n);  // R2
  AST_SYNC_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync_n |=> (state == SHIFT && cnt == '0));  // R3
  AST_WORD_EOD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!eod_n && !bmode) |=> eod_n);  // R4
  AST_BYTE_EOD_AT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bmode && $fell(eod_n)) |-> (state == GAP));  // R6
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GAP) |-> !dx);  // R5
  AST_SEC_NO_EOD: assert property (@(posedge clk) disable iff (!rst_n)
    sec |-> eod_n);  // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != IDLE && $past(state) != IDLE) |-> $stable(hold));  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE) |-> (!dx && fsync_n && eod_n));  // R1
endmodule

// File: tb/adc_serial_tx_test.sv
module adc_serial_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_mode = 1'b0, smp_valid = 1'b0, smp_secondary = 1'b0, fs_req = 1'b0;
  logic [15:0] smp_data = '0;
  logic dx, fsync_n, eod_n;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  adc_serial_tx uut (.clk, .rst_n, .byte_mode, .smp_valid, .smp_data,
                     .smp_secondary, .fs_req, .dx, .fsync_n, .eod_n);

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic exp_dx(int k, logic bm, logic [15:0] d);
    if (!bm) return (k >= 1 && k <= 16) ? d[16-k] : 1'b0;
    if (k >= 1 && k <= 8) return d[16-k];
    if (k >= 10 && k <= 17) return d[17-k];
    return 1'b0;
  endfunction

  function automatic logic exp_eod(int k, logic bm, logic sc);
    if (sc) return 1'b1;
    if (!bm) return (k == 17) ? 1'b0 : 1'b1;
    return (k >= 9 && k <= 17) ? 1'b0 : 1'b1;
  endfunction

  task automatic start_frame(input logic [15:0] d, input logic bm, input logic sc);
    @(negedge clk);
    smp_data = d; byte_mode = bm; smp_secondary = sc; smp_valid = 1'b1; fs_req = 1'b1;
  endtask

  task automatic chk_frame(input logic [15:0] d, input logic bm, input logic sc, input int n,
                           input logic do_pend, input logic [15:0] pd);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) smp_valid = 1'b0;
      chk(bm ? "R5" : "R3", $sformatf("dx k=%0d d=%h", k, d), dx, exp_dx(k, bm, d));
      chk("R2", $sformatf("fsync_n k=%0d", k), fsync_n, k != 0);
      chk(sc ? "R7" : (bm ? "R6" : "R4"), $sformatf("eod_n k=%0d bm=%0b", k, bm),
          eod_n, exp_eod(k, bm, sc));
      if (k == 3) begin
        smp_data = ~d; byte_mode = ~bm; smp_secondary = ~sc;  // R8
      end
      if (k == 5 && do_pend) begin
        smp_valid = 1'b1; smp_data = pd; byte_mode = 1'b0; smp_secondary = 1'b0;  // R9
      end
      if (k == 6 && do_pend) smp_valid = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] pats[4];
    pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5C3; pats[3] = 16'h1E69;
    #20;
    chk("R1", "reset dx", dx, 1'b0);
    chk("R1", "reset fsync_n", fsync_n, 1'b1);
    chk("R1", "reset eod_n", eod_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // R2: no start while the DSP is not ready
    smp_valid = 1'b1; smp_data = 16'h8001; fs_req = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2", "fsync_n with fs_req low", fsync_n, 1'b1);
      chk("R1", "idle dx", dx, 1'b0);
    end
    smp_valid = 1'b0;
    fs_req = 1'b1;
    chk_frame(16'h8001, 1'b0, 1'b0, 20, 1'b0, 16'h0);

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        start_frame(pats[p], m[1], m[0]);
        chk_frame(pats[p], m[1], m[0], 20, 1'b0, 16'h0);
      end
      for (int b = 0; b < 16; b++) begin
        start_frame(16'h1 << b, m[1], m[0]);
        chk_frame(16'h1 << b, m[1], m[0], 20, 1'b0, 16'h0);
      end
    end

    // R9: request during a frame is held and served at cycle 19
    start_frame(16'h3C5A, 1'b0, 1'b0);
    chk_frame(16'h3C5A, 1'b0, 1'b0, 19, 1'b1, 16'hB7E2);
    chk_frame(16'hB7E2, 1'b0, 1'b0, 20, 1'b0, 16'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9", "no extra frame", fsync_n, 1'b1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule